// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt sources into a pending register, masks them and raises one request line to the processor at a software-chosen 3-bit level. When the processor runs an acknowledge cycle at that level, the block returns an 8-bit vector. The vector names the highest-priority source that is both pending and unmasked.

The sources come in two kinds. General sources set their pending bit directly. Each serial channel has a front stage. In that stage a 13-bit event register is combined bitwise (AND) with a 13-bit channel mask. The channel's pending bit is set whenever any masked event bit is present.

The serial channels share a contiguous run of priority slots. A 2-bit field selects which channel ranks first within that run. Each channel keeps the same 5-bit source code however the run is ordered.

Top module: `vic_top`

Register map (addresses on `wr_addr_i` and `rd_addr_i`):

| Address | Register | Contents |
|---|---|---|
| 0 | CFG | bits [2:0] level, bits [5:3] vector high bits, bits [7:6] first-ranked serial channel |
| 1 | MASK | 28-bit source mask |
| 2 | PEND | 28-bit pending register, write-one-to-clear |
| 4+c | EVT of channel c | 13-bit event register, write-one-to-clear |
| 8+c | EMSK of channel c | 13-bit event mask |

## Requirements
- R1: General source j (`src_i[j]` high at a clock edge) sets pending slot j when j < 4, and slot j+4 otherwise. PEND at address 2 reads back the 28 pending slots.
- R2: Channel c owns an event register at address 4+c and an event mask at address 8+c. Bit b of `ser_evt_i[c*13+b]` sets event bit b, and writing 1 to an event bit clears it. Pending slot 4+c is set on each edge where (event AND mask) is nonzero. A masked-off event never sets that slot.
- R3: Writing 1 to a PEND bit clears it. If a set arrives in the same cycle as the clear, the set wins and the bit stays 1.
- R4: `irq_o` is high one cycle after any (PEND AND MASK) bit is nonzero. It goes low one clock after no such bit remains.
- R5: `irq_level_o` equals CFG bits [2:0].
- R6: Priority follows slot order, and the lowest slot wins. Slots 0 to 3 rank above the serial run, and slots 8 to 27 rank below it.
- R7: Serial channel c always reports code 4+c. Within slots 4 to 7 the order is: channel CFG[7:6] first, then the following channels, wrapping modulo 4.
- R8: One cycle after `iack_valid_i` is sampled with a matching level and an active source, `vector_valid_o` is high for one cycle. At the same time `vector_o` is {CFG[5:3], 5-bit code of the winner}.
- R9: `vector_valid_o` stays low in two cases: when `iack_level_i` differs from CFG[2:0], or when no source is pending and unmasked.
- R10: After reset, all registers read zero, and `irq_o`, `irq_level_o` and `vector_valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 24 | General source set strobes |
| ser_evt_i | input | 52 | Serial channel event set strobes, 13 per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 28 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 28 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Request level |
| iack_valid_i | input | 1 | Acknowledge cycle strobe |
| iack_level_i | input | 3 | Level being acknowledged |
| vector_valid_o | output | 1 | Vector response strobe |
| vector_o | output | 8 | Interrupt vector |

## Verification
The results arrive at different times after their stimulus:

| Stimulus | When the result is due |
|---|---|
| General source strobe | Pending bit after one edge; `irq_o` after the second edge |
| Serial event strobe | Pending bit after two edges; `irq_o` after three edges |
| Acknowledge | Vector response after the single edge following the acknowledge |
| Register write | Readback after one edge |

The bench drives all inputs on the falling edge. It samples only on later falling edges, counted to exactly those edges. The W1C and irq-drop cases are therefore checked on the first cycle in which they become visible.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  localparam int LVL_W  = 3;
  localparam int HI_W   = 3;
  localparam int CODE_W = 5;
  localparam int VEC_W  = HI_W + CODE_W;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CFG   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PEND  = 4'd2;
  localparam logic [ADDR_W-1:0] A_EVT0  = 4'd4;
  localparam logic [ADDR_W-1:0] A_EMSK0 = 4'd8;

  typedef struct packed {
    logic [SEL_W-1:0] top;
    logic [HI_W-1:0]  vhi;
    logic [LVL_W-1:0] lvl;
  } cfg_t;
endpackage

// File: rtl/vic_evt_stage.sv
`timescale 1ns/1ps
module vic_evt_stage #(
  parameter int NUM_EVT = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic               clr_we_i,
  input  logic               msk_we_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] evt_o,
  output logic [NUM_EVT-1:0] msk_o,
  output logic               req_o
);
  logic [NUM_EVT-1:0] evt_q, msk_q, clr;

  assign clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      msk_q <= '0;
    end else begin
      evt_q <= (evt_q & ~clr) | set_i;  // set beats clear
      if (msk_we_i) msk_q <= wdata_i;
    end
  end

  assign evt_o = evt_q;
  assign msk_o = msk_q;
  assign req_o = |(evt_q & msk_q);

  AST_EVT_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((evt_q & $past(set_i)) == $past(set_i))); // R2
endmodule

// File: rtl/vic_arb.sv
`timescale 1ns/1ps
module vic_arb
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 28,
  parameter int NUM_SER  = 4,
  parameter int SER_BASE = 4
) (
  input  logic [NUM_SRC-1:0] act_i,
  input  logic [SEL_W-1:0]   top_i,
  output logic               found_o,
  output logic [CODE_W-1:0]  slot_o
);
  // scan from lowest to highest priority; last hit wins
  always_comb begin
    found_o = 1'b0;
    slot_o  = '0;
    for (int i = NUM_SRC - 1; i >= SER_BASE + NUM_SER; i--) begin
      if (act_i[i]) begin
        found_o = 1'b1;
        slot_o  = CODE_W'(i);
      end
    end
    for (int k = NUM_SER - 1; k >= 0; k--) begin
      if (act_i[SER_BASE + ((int'(top_i) + k) % NUM_SER)]) begin
        found_o = 1'b1;
        slot_o  = CODE_W'(SER_BASE + ((int'(top_i) + k) % NUM_SER));
      end
    end
    for (int i = SER_BASE - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        found_o = 1'b1;
        slot_o  = CODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_top.sv
`timescale 1ns/1ps
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 28,
  parameter int NUM_SER  = 4,
  parameter int NUM_EVT  = 13,
  parameter int SER_BASE = 4,
  localparam int NUM_GEN = NUM_SRC - NUM_SER,
  localparam int DW      = NUM_SRC
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_GEN-1:0]         src_i,
  input  logic [NUM_SER*NUM_EVT-1:0] ser_evt_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [DW-1:0]              rd_data_o,
  output logic                       irq_o,
  output logic [LVL_W-1:0]           irq_level_o,
  input  logic                       iack_valid_i,
  input  logic [LVL_W-1:0]           iack_level_i,
  output logic                       vector_valid_o,
  output logic [VEC_W-1:0]           vector_o
);
  cfg_t               cfg_q;
  logic [NUM_SRC-1:0] mask_q, pend_q, pend_set, pend_clr, act;
  logic [NUM_SER-1:0] ser_req;
  logic [NUM_EVT-1:0] evt_w [NUM_SER];
  logic [NUM_EVT-1:0] emsk_w[NUM_SER];
  logic               found, irq_q, vv_q;
  logic [CODE_W-1:0]  win_slot;
  logic [VEC_W-1:0]   vec_q;

  // serial channel front stages
  for (genvar c = 0; c < NUM_SER; c++) begin : g_ser
    vic_evt_stage #(.NUM_EVT(NUM_EVT)) i_evt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (ser_evt_i[c*NUM_EVT +: NUM_EVT]),
      .clr_we_i(wr_en_i && wr_addr_i == A_EVT0 + ADDR_W'(c)),
      .msk_we_i(wr_en_i && wr_addr_i == A_EMSK0 + ADDR_W'(c)),
      .wdata_i (wr_data_i[NUM_EVT-1:0]),
      .evt_o   (evt_w[c]),
      .msk_o   (emsk_w[c]),
      .req_o   (ser_req[c])
    );
    assign pend_set[SER_BASE + c] = ser_req[c];
  end

  // general sources skip the serial slots
  for (genvar j = 0; j < NUM_GEN; j++) begin : g_gen
    if (j < SER_BASE) begin : g_lo
      assign pend_set[j] = src_i[j];
    end else begin : g_hi
      assign pend_set[j + NUM_SER] = src_i[j];
    end
  end

  assign pend_clr = (wr_en_i && wr_addr_i == A_PEND) ? wr_data_i : '0;
  assign act      = pend_q & mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_CFG)  cfg_q  <= cfg_t'(wr_data_i[$bits(cfg_t)-1:0]);
      if (wr_en_i && wr_addr_i == A_MASK) mask_q <= wr_data_i;
      pend_q <= (pend_q & ~pend_clr) | pend_set;
    end
  end

  vic_arb #(
    .NUM_SRC (NUM_SRC),
    .NUM_SER (NUM_SER),
    .SER_BASE(SER_BASE)
  ) i_arb (
    .act_i  (act),
    .top_i  (cfg_q.top),
    .found_o(found),
    .slot_o (win_slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vv_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= |act;
      vv_q  <= iack_valid_i && (iack_level_i == cfg_q.lvl) && found;
      if (iack_valid_i && (iack_level_i == cfg_q.lvl) && found)
        vec_q <= {cfg_q.vhi, win_slot};
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CFG)  rd_data_o = DW'(cfg_q);
    if (rd_addr_i == A_MASK) rd_data_o = mask_q;
    if (rd_addr_i == A_PEND) rd_data_o = pend_q;
    for (int c = 0; c < NUM_SER; c++) begin
      if (rd_addr_i == A_EVT0 + ADDR_W'(c))  rd_data_o = DW'(evt_w[c]);
      if (rd_addr_i == A_EMSK0 + ADDR_W'(c)) rd_data_o = DW'(emsk_w[c]);
    end
  end

  assign irq_o          = irq_q;
  assign irq_level_o    = cfg_q.lvl;
  assign vector_valid_o = vv_q;
  assign vector_o       = vec_q;

  AST_WIN_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> act[win_slot]); // R6
  AST_IDLE_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found |=> !irq_o); // R4
  AST_PEND_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_set != '0) |=> ((pend_q & $past(pend_set)) == $past(pend_set))); // R3
  AST_VEC_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |-> $past(iack_valid_i && iack_level_i == cfg_q.lvl && found)); // R9
  AST_VEC_HIGH_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |-> (vector_o[VEC_W-1:CODE_W] == $past(cfg_q.vhi))); // R8
endmodule

// File: tb/test_vic_top.sv
`timescale 1ns/1ps
module test_vic_top;
  import vic_pkg::*;

  localparam int NSRC = 28;
  localparam int NSER = 4;
  localparam int NEVT = 13;
  localparam int NGEN = NSRC - NSER;

  typedef struct packed {
    logic [NGEN-1:0] gen;
    logic [NSER-1:0] ser;
    logic [NSRC-1:0] mask;
    logic [1:0]      top;
    logic            valid;
    logic [4:0]      code;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{24'h000401, 4'h0, 28'hFFFFFFF, 2'd0, 1'b1, 5'd0},   // R6 slot 0 beats slot 14
    '{24'h000400, 4'h0, 28'hFFFFFFF, 2'd0, 1'b1, 5'd14},  // R1 gen 10 -> slot 14
    '{24'h000000, 4'h6, 28'hFFFFFFF, 2'd0, 1'b1, 5'd5},   // R7 top 0: ch1
    '{24'h000000, 4'h6, 28'hFFFFFFF, 2'd2, 1'b1, 5'd6},   // R7 top 2: ch2
    '{24'h000000, 4'h9, 28'hFFFFFFF, 2'd1, 1'b1, 5'd7},   // R7 top 1: ch3 before ch0
    '{24'h000008, 4'h1, 28'hFFFFFFF, 2'd0, 1'b1, 5'd3},   // R6 slot 3 above serial
    '{24'h000010, 4'h8, 28'hFFFFFFF, 2'd0, 1'b1, 5'd7},   // R6 serial above slot 8
    '{24'h800001, 4'h0, 28'hFFFFFFE, 2'd0, 1'b1, 5'd27},  // R6 masked slot 0 skipped
    '{24'hFFFFFF, 4'hF, 28'h0000000, 2'd0, 1'b0, 5'd0},   // R9 all masked
    '{24'h000000, 4'h0, 28'hFFFFFFF, 2'd0, 1'b0, 5'd0}    // R9 nothing pending
  };

  logic                 clk, rst_n;
  logic [NGEN-1:0]      src;
  logic [NSER*NEVT-1:0] ser_evt;
  logic                 wr_en;
  logic [ADDR_W-1:0]    wr_addr, rd_addr;
  logic [NSRC-1:0]      wr_data, rd_data;
  logic                 irq, iack_valid, vec_valid;
  logic [2:0]           irq_level, iack_level;
  logic [7:0]           vec;
  int                   n_tests = 0, n_fail = 0;

  vic_top i_vic_top (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .ser_evt_i(ser_evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .irq_level_o(irq_level),
    .iack_valid_i(iack_valid), .iack_level_i(iack_level),
    .vector_valid_o(vec_valid), .vector_o(vec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [NSRC-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [NSRC-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic ack(input logic [2:0] l);
    @(negedge clk);
    iack_valid = 1'b1; iack_level = l;
    @(negedge clk);
    iack_valid = 1'b0;
  endtask

  task automatic clear_all();
    for (int c = 0; c < NSER; c++) wr(A_EVT0 + ADDR_W'(c), '1);
    wr(A_PEND, '1);
  endtask

  function automatic logic [NSER*NEVT-1:0] spread(input logic [NSER-1:0] s);
    logic [NSER*NEVT-1:0] e = '0;
    for (int c = 0; c < NSER; c++) e[c*NEVT] = s[c];
    return e;
  endfunction

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [NSRC-1:0] d;
    rst_n = 1'b0; src = '0; ser_evt = '0; wr_en = 1'b0; wr_addr = '0;
    wr_data = '0; rd_addr = '0; iack_valid = 1'b0; iack_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 irq", irq, 0);
    chk("R10 vv", vec_valid, 0);
    chk("R10 lvl", irq_level, 0);
    rd(A_CFG, d);  chk("R10 cfg", d, 0);
    rd(A_MASK, d); chk("R10 mask", d, 0);
    rd(A_PEND, d); chk("R10 pend", d, 0);

    for (int c = 0; c < NSER; c++) wr(A_EMSK0 + ADDR_W'(c), '1);

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      clear_all();
      wr(A_MASK, ROWS[r].mask);
      wr(A_CFG, NSRC'({ROWS[r].top, 3'd5, 3'd4}));
      @(negedge clk);
      src = ROWS[r].gen; ser_evt = spread(ROWS[r].ser);
      @(negedge clk);
      src = '0; ser_evt = '0;
      repeat (2) @(negedge clk);
      chk($sformatf("R4 row%0d irq", r), irq, ROWS[r].valid);
      ack(3'd4);
      chk($sformatf("R9 row%0d vv", r), vec_valid, ROWS[r].valid);
      if (ROWS[r].valid)
        chk($sformatf("R8 R6 R7 row%0d vec", r), vec, {3'd5, ROWS[r].code});
    end

    // R5 level output
    chk("R5 lvl", irq_level, 4);

    // R1 / R9 / R8 directed
    clear_all();
    wr(A_MASK, '1);
    @(negedge clk); src = 24'h000001;
    @(negedge clk); src = '0;
    rd(A_PEND, d); chk("R1 pend", d, 28'h1);
    @(negedge clk);
    ack(3'd3);
    chk("R9 wrong level", vec_valid, 0);
    ack(3'd4);
    chk("R8 vv", vec_valid, 1);
    chk("R8 vec", vec, {3'd5, 5'd0});

    // R3 set beats clear
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_PEND; wr_data = 28'h1; src = 24'h000001;
    @(negedge clk);
    wr_en = 1'b0; src = '0;
    rd(A_PEND, d); chk("R3 set wins", d, 28'h1);
    wr(A_PEND, 28'h1);
    rd(A_PEND, d); chk("R3 cleared", d, 0);
    @(negedge clk);
    chk("R4 irq drops", irq, 0);

    // R2 front stage masking
    clear_all();
    wr(A_EMSK0 + 4'd1, '0);
    @(negedge clk); ser_evt = spread(4'h2);
    @(negedge clk); ser_evt = '0;
    @(negedge clk);
    rd(A_EVT0 + 4'd1, d); chk("R2 evt latched", d, 1);
    rd(A_PEND, d); chk("R2 masked no pend", d, 0);
    wr(A_EMSK0 + 4'd1, '1);
    @(negedge clk);
    rd(A_PEND, d); chk("R2 unmasked pend", d, 28'h20);
    wr(A_EVT0 + 4'd1, 28'h1);
    rd(A_EVT0 + 4'd1, d); chk("R2 evt cleared", d, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule